// File: doc/BRIEF.md
# Completion Queue Entry Writer

This block is a memory master that posts completion records into a circular queue kept in host memory. A record is built from a byte count, a subdevice byte, an opcode, a 32-bit address and a variable number of application bytes. The block writes these fields one memory transaction at a time over a request/acknowledge port that supports byte, halfword and word accesses. The host owns the ring's load and unload pointers, and both live in memory next to the entries, so the block keeps no copy of the ring state between operations.

Three operations are supported. An express post writes one record at the queue base and marks it with a sequence bit that toggles on every express post. A normal post fetches the load pointer, writes the record into the slot it names with a command/status flag merged into the subdevice byte, and writes the advanced pointer back. A probe fetches both pointers and reports whether another normal post would find a free slot. A one-cycle start pulse launches an operation and a one-cycle done pulse closes it.

Top module: `cqw_writer`

## Requirements
- R1: Each record is stored little-endian relative to its record address A: halfword byte count at A, subdevice byte at A+2, opcode byte at A+3, word address at A+4. The access size is coded on `mem_size` as 0 byte, 1 halfword, 2 word, and write data is taken from the low bits of `mem_wdata`.
- R2: After the 8 header bytes, exactly `esize`−8 application bytes are written at A+8 upward, byte k taken from `ent_app[8k+7:8k]`; the byte at A+`esize` is not written.
- R3: A start with `mode`=0 (express) toggles the sequence bit, writes the record at A=`base` with the new sequence bit ORed into bit 6 of the subdevice byte, ignores `cmd_stat`, and issues no memory read.
- R4: A pulse on `seq_clr` while idle returns the sequence bit to 0, so the next express post sets bit 6 of its subdevice byte.
- R5: A start with `mode`=1 (normal) reads the 16-bit load pointer P as a halfword at `base`+`esize`, writes the record at A=`base`+`esize`+4+P, and ORs `cmd_stat` into bit 7 of the subdevice byte.
- R6: In a normal post with nonzero `depth`, the halfword at `base`+`esize` is rewritten as (P+`esize`) mod (`esize`×`depth`).
- R7: In a normal post with `depth`=0 the pointer halfword is left unchanged.
- R8: A start with `mode`=2 or 3 (probe) reads the load pointer and then the unload pointer U at `base`+`esize`+2 and writes nothing; `space_ok` then holds 1 when `depth` is nonzero and (P+`esize`) mod (`esize`×`depth`) differs from U, else 0, until the next probe.
- R9: Only one transaction is outstanding: `mem_req` stays high with address, size and data held until `mem_ack`; `busy` is high from the cycle after start until done; `done` lasts one cycle.
- R10: After reset `busy`, `done`, `mem_req` and `space_ok` are 0 and the sequence bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse launching an operation while idle |
| mode | input | 2 | 0 express, 1 normal, 2 or 3 probe |
| cmd_stat | input | 1 | Flag merged into subdevice bit 7 in normal posts |
| seq_clr | input | 1 | Clears the sequence bit |
| base | input | AW (16) | Queue base address |
| depth | input | DEPTH_W (8) | Number of ring slots |
| esize | input | ESZ_W (8) | Record size in bytes, 8 to 8+APP_MAX |
| ent_bcount | input | 16 | Record byte count field |
| ent_subdev | input | 8 | Record subdevice field |
| ent_opcode | input | 8 | Record opcode field |
| ent_addr | input | 32 | Record address field |
| ent_app | input | APP_MAX×8 (64) | Application bytes, byte 0 lowest |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| space_ok | output | 1 | Result of the last probe |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | Access size code |
| mem_addr | output | AW (16) | Byte address |
| mem_wdata | output | 32 | Write data, right-aligned |
| mem_ack | input | 1 | One-cycle acknowledge ending a transaction |
| mem_rdata | input | 32 | Read data, right-aligned, valid with ack |

## Verification
The assertions take for granted that `esize` lies between 8 and 8+APP_MAX at start, that a stored load pointer is below the ring size so one conditional subtraction wraps it, that start and `seq_clr` arrive only while idle, and that the memory answers each request with a single-cycle acknowledge. The stimulus seeds every ring with pointers inside the ring, keeps record sizes between 8 and 16, pulses start and `seq_clr` only between operations, and uses a memory model that acknowledges after 0 to 3 wait cycles and never twice for one request.

// File: rtl/cqw_pkg.sv
package cqw_pkg;
   typedef enum logic [1:0] {
      MODE_EXPRESS = 2'd0,
      MODE_NORMAL  = 2'd1,
      MODE_PROBE   = 2'd2,
      MODE_PROBE_B = 2'd3
   } cqw_mode_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } cqw_size_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_LP,
      ST_RD_ULP,
      ST_WR_CNT,
      ST_WR_SUB,
      ST_WR_OPC,
      ST_WR_ADR,
      ST_WR_APP,
      ST_WR_LP,
      ST_FIN
   } cqw_state_e;

   localparam int unsigned HDR_BYTES  = 8;
   localparam int unsigned PAIR_BYTES = 4;
endpackage

// File: rtl/cqw_ring_math.sv
module cqw_ring_math #(
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned ESZ_W     = 8,
   parameter int unsigned DEPTH_W   = 8,
   parameter bit          EXACT_MOD = 1'b0
) (
   input  logic [PTR_W-1:0]   lp,
   input  logic [PTR_W-1:0]   ulp,
   input  logic [ESZ_W-1:0]   esize,
   input  logic [DEPTH_W-1:0] depth,
   output logic [PTR_W-1:0]   next_lp,
   output logic               has_room
);
   localparam int unsigned RING_W = ESZ_W + DEPTH_W;
   localparam int unsigned CW     = ((PTR_W + 1 > RING_W) ? PTR_W + 1 : RING_W) + 1;

   logic [CW-1:0] ring_c;
   logic [CW-1:0] sum_c;
   logic [CW-1:0] wrap_c;

   assign ring_c = CW'(esize) * CW'(depth);
   assign sum_c  = CW'(lp) + CW'(esize);

   generate
      if (EXACT_MOD) begin : g_exact
         assign wrap_c = (depth == '0) ? sum_c : (sum_c % ring_c);
      end else begin : g_subtract
         assign wrap_c = (sum_c >= ring_c) ? (sum_c - ring_c) : sum_c;
      end
   endgenerate

   assign next_lp  = PTR_W'(wrap_c);
   assign has_room = (depth != '0) && (next_lp != ulp);

   always_comb begin
      if ((depth != '0) && (CW'(lp) < ring_c))
         assert_wrap_in_ring_R6: assert (wrap_c < ring_c);
   end
endmodule

// File: rtl/cqw_seq_bit.sv
module cqw_seq_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tgl,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= 1'b0;
      else if (clr) q <= 1'b0;
      else if (tgl) q <= ~q;
   end

   assert_seq_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !q);

   assert_seq_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tgl && !clr) |=> (q != $past(q)));
endmodule

// File: rtl/cqw_engine.sv
module cqw_engine
   import cqw_pkg::*;
#(
   parameter int unsigned AW        = 16,
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned ESZ_W     = 8,
   parameter int unsigned DEPTH_W   = 8,
   parameter int unsigned APP_MAX   = 8,
   parameter bit          EXACT_MOD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           mode,
   input  logic                 cmd_stat,
   input  logic [AW-1:0]        base,
   input  logic [DEPTH_W-1:0]   depth,
   input  logic [ESZ_W-1:0]     esize,
   input  logic [15:0]          ent_bcount,
   input  logic [7:0]           ent_subdev,
   input  logic [7:0]           ent_opcode,
   input  logic [31:0]          ent_addr,
   input  logic [APP_MAX*8-1:0] ent_app,
   input  logic                 seq_q,
   output logic                 seq_tgl,
   output logic                 busy,
   output logic                 done,
   output logic                 space_ok,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [1:0]           mem_size,
   output logic [AW-1:0]        mem_addr,
   output logic [31:0]          mem_wdata,
   input  logic                 mem_ack,
   input  logic [31:0]          mem_rdata
);
   localparam int unsigned APP_W = APP_MAX * 8;
   localparam int unsigned IDX_W = (APP_MAX > 1) ? $clog2(APP_MAX) : 1;

   generate
      if (AW < PTR_W) begin : g_bad_aw
         $error("address width must cover the pointer width");
      end
      if (PTR_W > 32) begin : g_bad_ptr
         $error("pointer must fit in one data word");
      end
      if (APP_MAX < 1) begin : g_bad_app
         $error("at least one application byte slot is needed");
      end
      if ((1 << ESZ_W) <= (HDR_BYTES + APP_MAX)) begin : g_bad_esz
         $error("record size field too narrow");
      end
   endgenerate

   cqw_state_e           st;
   cqw_state_e           after_body;
   cqw_mode_e            mode_q;
   cqw_size_e            size_c;
   logic                 cmd_q;
   logic [AW-1:0]        base_q;
   logic [DEPTH_W-1:0]   depth_q;
   logic [ESZ_W-1:0]     esize_q;
   logic [15:0]          bc_q;
   logic [7:0]           sd_q;
   logic [7:0]           op_q;
   logic [31:0]          ad_q;
   logic [APP_W-1:0]     app_q;
   logic [PTR_W-1:0]     lp_q;
   logic [AW-1:0]        ent_base_q;
   logic [IDX_W-1:0]     app_idx;
   logic [PTR_W-1:0]     next_lp;
   logic                 room;
   logic                 has_app;
   logic                 last_app;
   logic [7:0]           sub_final;
   logic [AW-1:0]        ptr_addr;

   cqw_ring_math #(
      .PTR_W     (PTR_W),
      .ESZ_W     (ESZ_W),
      .DEPTH_W   (DEPTH_W),
      .EXACT_MOD (EXACT_MOD)
   ) u_ring (
      .lp       (lp_q),
      .ulp      (mem_rdata[PTR_W-1:0]),
      .esize    (esize_q),
      .depth    (depth_q),
      .next_lp  (next_lp),
      .has_room (room)
   );

   assign has_app   = esize_q > ESZ_W'(HDR_BYTES);
   assign last_app  = (ESZ_W'(app_idx) + ESZ_W'(HDR_BYTES + 1)) == esize_q;
   assign after_body = ((mode_q == MODE_NORMAL) && (depth_q != '0)) ? ST_WR_LP : ST_FIN;
   assign sub_final = (mode_q == MODE_EXPRESS) ? (sd_q | {1'b0, seq_q, 6'b0})
                                               : (sd_q | {cmd_q, 7'b0});
   assign ptr_addr  = base_q + AW'(esize_q);
   assign seq_tgl   = (st == ST_IDLE) && start && (cqw_mode_e'(mode) == MODE_EXPRESS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         mode_q     <= MODE_EXPRESS;
         cmd_q      <= 1'b0;
         base_q     <= '0;
         depth_q    <= '0;
         esize_q    <= '0;
         bc_q       <= '0;
         sd_q       <= '0;
         op_q       <= '0;
         ad_q       <= '0;
         app_q      <= '0;
         lp_q       <= '0;
         ent_base_q <= '0;
         app_idx    <= '0;
         space_ok   <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  mode_q  <= cqw_mode_e'(mode);
                  cmd_q   <= cmd_stat;
                  base_q  <= base;
                  depth_q <= depth;
                  esize_q <= esize;
                  bc_q    <= ent_bcount;
                  sd_q    <= ent_subdev;
                  op_q    <= ent_opcode;
                  ad_q    <= ent_addr;
                  app_q   <= ent_app;
                  if (cqw_mode_e'(mode) == MODE_EXPRESS) begin
                     ent_base_q <= base;
                     st         <= ST_WR_CNT;
                  end else begin
                     st <= ST_RD_LP;
                  end
               end
            end
            ST_RD_LP: begin
               if (mem_ack) begin
                  lp_q       <= mem_rdata[PTR_W-1:0];
                  ent_base_q <= base_q + AW'(esize_q) + AW'(PAIR_BYTES)
                                + AW'(mem_rdata[PTR_W-1:0]);
                  st         <= (mode_q == MODE_NORMAL) ? ST_WR_CNT : ST_RD_ULP;
               end
            end
            ST_RD_ULP: begin
               if (mem_ack) begin
                  space_ok <= room;
                  st       <= ST_FIN;
               end
            end
            ST_WR_CNT: if (mem_ack) st <= ST_WR_SUB;
            ST_WR_SUB: if (mem_ack) st <= ST_WR_OPC;
            ST_WR_OPC: if (mem_ack) st <= ST_WR_ADR;
            ST_WR_ADR: begin
               if (mem_ack) begin
                  app_idx <= '0;
                  st      <= has_app ? ST_WR_APP : after_body;
               end
            end
            ST_WR_APP: begin
               if (mem_ack) begin
                  if (last_app) st <= after_body;
                  else          app_idx <= app_idx + 1'b1;
               end
            end
            ST_WR_LP: if (mem_ack) st <= ST_FIN;
            ST_FIN:   st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_addr  = '0;
      mem_wdata = '0;
      size_c    = SZ_BYTE;
      unique case (st)
         ST_RD_LP: begin
            mem_addr = ptr_addr;
            size_c   = SZ_HALF;
         end
         ST_RD_ULP: begin
            mem_addr = ptr_addr + AW'(2);
            size_c   = SZ_HALF;
         end
         ST_WR_CNT: begin
            mem_addr  = ent_base_q;
            mem_wdata = {16'b0, bc_q};
            size_c    = SZ_HALF;
         end
         ST_WR_SUB: begin
            mem_addr  = ent_base_q + AW'(2);
            mem_wdata = {24'b0, sub_final};
         end
         ST_WR_OPC: begin
            mem_addr  = ent_base_q + AW'(3);
            mem_wdata = {24'b0, op_q};
         end
         ST_WR_ADR: begin
            mem_addr  = ent_base_q + AW'(4);
            mem_wdata = ad_q;
            size_c    = SZ_WORD;
         end
         ST_WR_APP: begin
            mem_addr  = ent_base_q + AW'(HDR_BYTES) + AW'(app_idx);
            mem_wdata = {24'b0, app_q[{app_idx, 3'b000} +: 8]};
         end
         ST_WR_LP: begin
            mem_addr  = ptr_addr;
            mem_wdata = 32'(next_lp);
            size_c    = SZ_HALF;
         end
         default: ;
      endcase
   end

   assign mem_size = size_c;
   assign mem_req  = (st != ST_IDLE) && (st != ST_FIN);
   assign mem_we   = (st != ST_RD_LP) && (st != ST_RD_ULP);
   assign busy     = (st != ST_IDLE);
   assign done     = (st == ST_FIN);

   assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_size) && $stable(mem_wdata)));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req);

   assert_express_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && (mode_q == MODE_EXPRESS)) |-> mem_we);

   assert_no_ptr_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we && (mode_q == MODE_NORMAL) && (mem_addr == ptr_addr))
      |-> (depth_q != '0));

   assert_esize_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_IDLE) && start) |->
      ((esize >= ESZ_W'(HDR_BYTES)) && (esize <= ESZ_W'(HDR_BYTES + APP_MAX))));
endmodule

// File: rtl/cqw_writer.sv
module cqw_writer #(
   parameter int unsigned AW        = 16,
   parameter int unsigned PTR_W     = 16,
   parameter int unsigned ESZ_W     = 8,
   parameter int unsigned DEPTH_W   = 8,
   parameter int unsigned APP_MAX   = 8,
   parameter bit          EXACT_MOD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           mode,
   input  logic                 cmd_stat,
   input  logic                 seq_clr,
   input  logic [AW-1:0]        base,
   input  logic [DEPTH_W-1:0]   depth,
   input  logic [ESZ_W-1:0]     esize,
   input  logic [15:0]          ent_bcount,
   input  logic [7:0]           ent_subdev,
   input  logic [7:0]           ent_opcode,
   input  logic [31:0]          ent_addr,
   input  logic [APP_MAX*8-1:0] ent_app,
   output logic                 busy,
   output logic                 done,
   output logic                 space_ok,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [1:0]           mem_size,
   output logic [AW-1:0]        mem_addr,
   output logic [31:0]          mem_wdata,
   input  logic                 mem_ack,
   input  logic [31:0]          mem_rdata
);
   logic seq_q;
   logic seq_tgl;

   cqw_seq_bit u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (seq_clr),
      .tgl   (seq_tgl),
      .q     (seq_q)
   );

   cqw_engine #(
      .AW        (AW),
      .PTR_W     (PTR_W),
      .ESZ_W     (ESZ_W),
      .DEPTH_W   (DEPTH_W),
      .APP_MAX   (APP_MAX),
      .EXACT_MOD (EXACT_MOD)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mode       (mode),
      .cmd_stat   (cmd_stat),
      .base       (base),
      .depth      (depth),
      .esize      (esize),
      .ent_bcount (ent_bcount),
      .ent_subdev (ent_subdev),
      .ent_opcode (ent_opcode),
      .ent_addr   (ent_addr),
      .ent_app    (ent_app),
      .seq_q      (seq_q),
      .seq_tgl    (seq_tgl),
      .busy       (busy),
      .done       (done),
      .space_ok   (space_ok),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_size   (mem_size),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata)
   );
endmodule

// File: tb/cqw_writer_tb.sv
`timescale 1ns/1ps
module cqw_writer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  mode = 2'd0;
   logic        cmd_stat = 1'b0;
   logic        seq_clr = 1'b0;
   logic [15:0] base = '0;
   logic [7:0]  depth = '0;
   logic [7:0]  esize = 8'd8;
   logic [15:0] ent_bcount = '0;
   logic [7:0]  ent_subdev = '0;
   logic [7:0]  ent_opcode = '0;
   logic [31:0] ent_addr = '0;
   logic [63:0] ent_app = '0;
   logic        busy, done, space_ok, mem_req, mem_we;
   logic [1:0]  mem_size;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;

   always #2.5 clk = ~clk;

   cqw_writer u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .cmd_stat(cmd_stat),
      .seq_clr(seq_clr), .base(base), .depth(depth), .esize(esize),
      .ent_bcount(ent_bcount), .ent_subdev(ent_subdev), .ent_opcode(ent_opcode),
      .ent_addr(ent_addr), .ent_app(ent_app), .busy(busy), .done(done),
      .space_ok(space_ok), .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   // memory model: little-endian bytes, one acknowledge per request
   logic [7:0] mem [0:255];
   int         cur_lat = 0;
   int         wcnt = 0;
   int         rd_total = 0;
   logic [7:0] ma;

   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack   <= 1'b0;
         mem_rdata <= '0;
         wcnt      <= 0;
      end else begin
         mem_ack <= 1'b0;
         if (mem_req && !mem_ack) begin
            if (wcnt >= cur_lat) begin
               mem_ack <= 1'b1;
               wcnt    <= 0;
               ma = mem_addr[7:0];
               if (mem_we) begin
                  mem[ma] = mem_wdata[7:0];
                  if (mem_size != 2'd0) mem[ma + 8'd1] = mem_wdata[15:8];
                  if (mem_size == 2'd2) begin
                     mem[ma + 8'd2] = mem_wdata[23:16];
                     mem[ma + 8'd3] = mem_wdata[31:24];
                  end
               end else begin
                  mem_rdata <= {mem[ma + 8'd3], mem[ma + 8'd2], mem[ma + 8'd1], mem[ma]};
                  rd_total  <= rd_total + 1;
               end
            end else begin
               wcnt <= wcnt + 1;
            end
         end
      end
   end

   typedef struct packed {
      logic [1:0]  mode;
      logic [1:0]  lat;
      logic [7:0]  base;
      logic [7:0]  esz;
      logic [7:0]  dep;
      logic [15:0] lp0;
      logic [15:0] ulp0;
      logic        cmd;
      logic [15:0] exp_lp;
      logic        exp_sp;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{2'd1, 2'd0, 8'h10, 8'd12, 8'd4, 16'd0,  16'd0, 1'b1, 16'd12, 1'b0},
      '{2'd1, 2'd1, 8'h10, 8'd12, 8'd4, 16'd36, 16'd0, 1'b0, 16'd0,  1'b0},
      '{2'd1, 2'd2, 8'h40, 8'd8,  8'd3, 16'd8,  16'd0, 1'b1, 16'd16, 1'b0},
      '{2'd1, 2'd0, 8'h40, 8'd8,  8'd0, 16'd8,  16'd0, 1'b1, 16'd8,  1'b0},
      '{2'd1, 2'd3, 8'h20, 8'd16, 8'd2, 16'd16, 16'd0, 1'b0, 16'd0,  1'b0},
      '{2'd2, 2'd1, 8'h10, 8'd12, 8'd4, 16'd36, 16'd0, 1'b0, 16'd36, 1'b0},
      '{2'd2, 2'd0, 8'h10, 8'd12, 8'd4, 16'd12, 16'd0, 1'b0, 16'd12, 1'b1},
      '{2'd2, 2'd2, 8'h10, 8'd12, 8'd0, 16'd12, 16'd0, 1'b0, 16'd12, 1'b0},
      '{2'd0, 2'd1, 8'h80, 8'd16, 8'd2, 16'd0,  16'd0, 1'b0, 16'd0,  1'b0},
      '{2'd0, 2'd3, 8'h80, 8'd9,  8'd2, 16'd0,  16'd0, 1'b1, 16'd0,  1'b0},
      '{2'd3, 2'd0, 8'h10, 8'd12, 8'd4, 16'd24, 16'd0, 1'b0, 16'd24, 1'b1}
   };

   int n_chk = 0;
   int n_fail = 0;
   bit exp_seq = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] app_byte(input int i, input int j);
      return 8'(8'h60 + i * 16 + j);
   endfunction

   function automatic logic [15:0] rd_half(input logic [7:0] a);
      return {mem[a + 8'd1], mem[a]};
   endfunction

   task automatic run_vec(input vec_t v, input int idx);
      logic [7:0] loc;
      logic [7:0] pa;
      logic [7:0] sd;
      int rd0;
      int guard;
      for (int k = 0; k < 256; k++) mem[k] = 8'hEE;
      pa = v.base + v.esz;
      if (v.mode != 2'd0) begin
         mem[pa]        = v.lp0[7:0];
         mem[pa + 8'd1] = v.lp0[15:8];
         mem[pa + 8'd2] = v.ulp0[7:0];
         mem[pa + 8'd3] = v.ulp0[15:8];
      end
      sd         = 8'(8'h11 + idx);
      cur_lat    = int'(v.lat);
      mode       = v.mode;
      base       = {8'h00, v.base};
      esize      = v.esz;
      depth      = v.dep;
      cmd_stat   = v.cmd;
      ent_bcount = 16'(16'hA000 + idx * 16'h0111);
      ent_subdev = sd;
      ent_opcode = 8'(8'h30 + idx);
      ent_addr   = 32'hC0DE0000 + 32'(idx);
      for (int j = 0; j < 8; j++) ent_app[j*8 +: 8] = app_byte(idx, j);
      rd0   = rd_total;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R9 busy after start", {31'b0, busy}, 32'd1);
      guard = 0;
      while (!done && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      chk("R9 done seen", {31'b0, done}, 32'd1);
      @(negedge clk);
      chk("R9 done one cycle", {31'b0, done}, 32'd0);
      if (v.mode == 2'd0) begin
         exp_seq = ~exp_seq;
         loc = v.base;
         chk("R3 express no reads", 32'(rd_total - rd0), 32'd0);
         chk("R3 subdevice seq bit", {24'b0, mem[loc + 8'd2]}, {24'b0, sd | {1'b0, exp_seq, 6'b0}});
      end else if (v.mode == 2'd1) begin
         loc = pa + 8'd4 + v.lp0[7:0];
         chk("R5 one pointer read", 32'(rd_total - rd0), 32'd1);
         chk("R5 subdevice cmd bit", {24'b0, mem[loc + 8'd2]}, {24'b0, sd | {v.cmd, 7'b0}});
         if (v.dep != 8'd0) chk("R6 pointer writeback", {16'b0, rd_half(pa)}, {16'b0, v.exp_lp});
         else               chk("R7 pointer unchanged", {16'b0, rd_half(pa)}, {16'b0, v.exp_lp});
      end else begin
         loc = 8'h00;
         chk("R8 two pointer reads", 32'(rd_total - rd0), 32'd2);
         chk("R8 space flag", {31'b0, space_ok}, {31'b0, v.exp_sp});
         chk("R8 load ptr untouched", {16'b0, rd_half(pa)}, {16'b0, v.lp0});
         chk("R8 unload ptr untouched", {16'b0, rd_half(pa + 8'd2)}, {16'b0, v.ulp0});
      end
      if (v.mode <= 2'd1) begin
         chk("R1 byte count", {16'b0, rd_half(loc)}, {16'b0, ent_bcount});
         chk("R1 opcode", {24'b0, mem[loc + 8'd3]}, {24'b0, ent_opcode});
         chk("R1 address word", {mem[loc + 8'd7], mem[loc + 8'd6], mem[loc + 8'd5], mem[loc + 8'd4]},
             ent_addr);
         for (int j = 0; j < int'(v.esz) - 8; j++)
            chk("R2 app byte", {24'b0, mem[loc + 8'd8 + 8'(j)]}, {24'b0, app_byte(idx, j)});
         chk("R2 no write past record", {24'b0, mem[loc + v.esz]}, 32'h0000_00EE);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R10 busy in reset", {31'b0, busy}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 busy after reset", {31'b0, busy}, 32'd0);
      chk("R10 done after reset", {31'b0, done}, 32'd0);
      chk("R10 no request after reset", {31'b0, mem_req}, 32'd0);
      chk("R10 space flag after reset", {31'b0, space_ok}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         run_vec(TBL[i], i);
         @(negedge clk);
      end

      // R4: clear between two express posts
      run_vec('{2'd0, 2'd0, 8'h80, 8'd8, 8'd1, 16'd0, 16'd0, 1'b0, 16'd0, 1'b0}, 11);
      seq_clr = 1'b1;
      @(negedge clk);
      seq_clr = 1'b0;
      exp_seq = 1'b0;
      @(negedge clk);
      run_vec('{2'd0, 2'd1, 8'h80, 8'd8, 8'd1, 16'd0, 16'd0, 1'b0, 16'd0, 1'b0}, 12);
      chk("R4 seq bit set after clear", {31'b0, mem[8'h82][6]}, 32'd1);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end
endmodule